// File: doc/BRIEF.md
# IDE Device Task-File Register Set

This block models the register file that an IDE disk presents on its host bus. Two active-low chip selects choose between the command block and the control block. A three-bit offset picks a register inside the chosen block. Active-low read and write strobes perform the accesses. The block stores the command parameters (sector count, sector number, cylinder, head, device bit and features). It also keeps the device status and error byte, owns the interrupt request line, and runs a soft reset requested through the device-control register.

An internal command engine sits behind the block. When the host writes a command, the block pulses `cmd_start` and presents every parameter on `tf_params`. The engine later reports completion through `be_done`, together with a data-request flag and an error code. The engine also drives several live status bits directly: index, corrected data, seek complete, write fault and writing.

Media handling, command execution and the 16-bit data port are outside this block. The block is meant to sit in the device half of an IDE bridge or emulator.

Top module: `tf_regset`

## Requirements
- R1: An access counts only on the cycle in which its strobe goes low.
  - The command block is selected when `cs0_n`=0 and `cs1_n`=1.
  - The control block is selected when `cs0_n`=1 and `cs1_n`=0.
  - Command-block offsets 2, 3, 4 and 5 (sector count, sector number, cylinder low, cylinder high) read back exactly what was last written.
  - Read data and `rdata_oe`=1 appear one clock after the read strobe falls.
  - Offset 0, and any access with both selects low, gives `rdata_oe`=0 and `rdata`=0.
- R2: Command-block offset 6 stores the head in bits 3..0 and the device bit in bit 4. It reads back as {3'b101, device, head}.
- R3: Writing command-block offset 1 loads the features byte, which appears on `tf_params[55:48]`. Reading offset 1 returns the error code instead.
- R4: Writing command-block offset 7 behaves as follows:
  - If the device is selected and not busy, the write pulses `cmd_start` for one cycle, places the code on `tf_params[7:0]`, sets BSY (status bit 7), clears DRQ (bit 3) and ERR (bit 0), and drops any pending interrupt.
  - While BSY is set, the write is ignored.
- R5: A `be_done` pulse while busy clears BSY, loads DRQ from `be_drq`, sets ERR when `be_err` is nonzero, loads the error register (offset 1) with `be_err`, and makes an interrupt pending.
- R6: `irq_o` goes high one clock after an interrupt becomes pending, provided the interrupt-disable bit is 0 and the device is selected.
- R7: Status reads work as follows:
  - Reading the primary status (command offset 7) clears the pending interrupt, so `irq_o` falls one clock later.
  - Reading the alternate status (control offset 6) returns the same byte and leaves the pending interrupt alone.
- R8: Device-control bit 1 set to 1 holds `irq_o` low. A completion that arrives while masked stays pending and drives `irq_o` once the bit returns to 0.
- R9: Writing device control with bit 2 set puts the device into soft reset until a later write clears bit 2. During soft reset:
  - Status reads 0x80 (BSY=1, RDY=0).
  - Sector count and sector number return to 1; features, cylinder, head and device return to 0.
  - Any pending interrupt is dropped.
  When bit 2 is cleared, status becomes 0x40.
- R10: The device is selected only while head/device bit 4 equals the `is_slave` strap.
  - When it is not selected, no read gets a response and command writes are ignored.
  - Parameter register writes are accepted in either case.
- R11: Control offset 7 reads {0, `be_writing`, inverted head[3:0], device bit, inverted device bit}.
- R12: Status bits 1, 2, 4 and 5 follow `be_index`, `be_corr`, `be_seek_ok` and `be_wfault`.
- R13: After `rst`:
  - Status reads 0x40.
  - Sector count and sector number read 1.
  - Head/device reads 0xA0.
  - `irq_o` and `cmd_start` are 0.
- R14: Holding a write strobe low over several clocks loads only the data present on the clock in which the strobe fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_slave | input | 1 | Strap: 1 when this device answers to device bit 1 |
| cs0_n | input | 1 | Command-block select, active low |
| cs1_n | input | 1 | Control-block select, active low |
| addr | input | 3 | Register offset within the block |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rdata_oe | output | 1 | High while `rdata` is driven by this device |
| irq_o | output | 1 | Interrupt request to the host |
| be_done | input | 1 | Engine: command finished (one-cycle pulse) |
| be_drq | input | 1 | Engine: data request state at completion |
| be_err | input | 8 | Engine: error code at completion, 0 means no error |
| be_index | input | 1 | Engine: index indication |
| be_corr | input | 1 | Engine: corrected-data indication |
| be_seek_ok | input | 1 | Engine: seek complete |
| be_wfault | input | 1 | Engine: write fault |
| be_writing | input | 1 | Engine: writing in progress |
| cmd_start | output | 1 | One-cycle pulse when a command is accepted |
| tf_params | output | 56 | {features, count, sector, cyl low, cyl high, head/device, command} |

## Verification
The bench targets several corner cases, each with a visible failure mode:

- **Primary versus alternate status.** A design that clears the interrupt on an alternate-status read would drop `irq_o` early. One that fails to clear it on a primary-status read would leave `irq_o` stuck high.
- **Masking.** A design that discards a completion while masked, instead of keeping it pending, would never raise `irq_o` after the mask bit is cleared.
- **Soft reset.** The bench checks that soft reset both restores the parameter defaults and drops a pending interrupt. It also checks that commands written while busy or while deselected never pulse `cmd_start`.
- **Held strobes.** A design that treats a held strobe as a level rather than an edge would load the last data value instead of the first.
- **Inverted fields.** Wrong encodings show up as a changed byte on reads of the head/device and drive-address registers.

// File: rtl/tf_pkg.sv
`timescale 1ns/1ps
package tf_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;
  localparam int HEAD_W = 4;
  localparam int NUM_PARAM_BYTES = 7;

  // command block offsets
  localparam logic [OFS_W-1:0] OFS_ERRFEAT = 3'd1;
  localparam logic [OFS_W-1:0] OFS_COUNT   = 3'd2;
  localparam logic [OFS_W-1:0] OFS_SECTOR  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_CYL_LO  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_CYL_HI  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_HEADDEV = 3'd6;
  localparam logic [OFS_W-1:0] OFS_STATCMD = 3'd7;
  // control block offsets
  localparam logic [OFS_W-1:0] OFS_ALTCTL  = 3'd6;
  localparam logic [OFS_W-1:0] OFS_DRVADR  = 3'd7;

  // device control bit positions
  localparam int DC_MASK_BIT = 1;
  localparam int DC_RST_BIT  = 2;
  // fixed upper bits of head/device readback
  localparam logic [2:0] HD_FIXED = 3'b101;

  typedef struct packed {
    logic cmd_rd;
    logic cmd_wr;
    logic ctl_rd;
    logic ctl_wr;
    logic [OFS_W-1:0] ofs;
  } bus_op_t;
endpackage

// File: rtl/tf_decode.sv
`timescale 1ns/1ps
module tf_decode
  import tf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cs0_n,
  input  logic             cs1_n,
  input  logic [OFS_W-1:0] addr,
  input  logic             rd_n,
  input  logic             wr_n,
  output bus_op_t          op
);
  logic rd_q, wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
    end
  end

  logic rd_fall, wr_fall, cmd_blk, ctl_blk;
  assign rd_fall = !rd_n && rd_q;
  assign wr_fall = !wr_n && wr_q;
  assign cmd_blk = !cs0_n && cs1_n;
  assign ctl_blk = cs0_n && !cs1_n;

  always_comb begin
    op.cmd_rd = rd_fall && cmd_blk;
    op.cmd_wr = wr_fall && cmd_blk;
    op.ctl_rd = rd_fall && ctl_blk;
    op.ctl_wr = wr_fall && ctl_blk;
    op.ofs    = addr;
  end
endmodule

// File: rtl/tf_store.sv
`timescale 1ns/1ps
module tf_store
  import tf_pkg::*;
#(
  parameter int CNT_DEF = 1,
  parameter int SEC_DEF = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              cmd_go,
  output logic [BYTE_W-1:0] feat,
  output logic [BYTE_W-1:0] count,
  output logic [BYTE_W-1:0] sector,
  output logic [BYTE_W-1:0] cyl_lo,
  output logic [BYTE_W-1:0] cyl_hi,
  output logic [HEAD_W-1:0] head,
  output logic              dev,
  output logic [BYTE_W-1:0] cmd
);
  // one plain byte register per offset 1..5, defaults picked per offset
  for (genvar g = 1; g <= 5; g++) begin : g_byte
    localparam logic [BYTE_W-1:0] DEF =
      (g == int'(OFS_COUNT))  ? BYTE_W'(CNT_DEF) :
      (g == int'(OFS_SECTOR)) ? BYTE_W'(SEC_DEF) : '0;
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst || soft_rst)
        q <= DEF;
      else if (wr_en && wr_ofs == OFS_W'(g))
        q <= wdata;
    end
  end

  assign feat   = g_byte[1].q;
  assign count  = g_byte[2].q;
  assign sector = g_byte[3].q;
  assign cyl_lo = g_byte[4].q;
  assign cyl_hi = g_byte[5].q;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      head <= '0;
      dev  <= 1'b0;
      cmd  <= '0;
    end else begin
      if (wr_en && wr_ofs == OFS_HEADDEV) begin
        head <= wdata[HEAD_W-1:0];
        dev  <= wdata[HEAD_W];
      end
      if (cmd_go)
        cmd <= wdata;
    end
  end
endmodule

// File: rtl/tf_ctrl.sv
`timescale 1ns/1ps
module tf_ctrl
  import tf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              cmd_wr_req,
  input  logic              stat_rd,
  input  logic              ctl_wr,
  input  logic              dc_mask,
  input  logic              dc_rst,
  input  logic              be_done,
  input  logic              be_drq,
  input  logic [BYTE_W-1:0] be_err,
  output logic              cmd_go,
  output logic              bsy,
  output logic              rdy,
  output logic              drq,
  output logic              err,
  output logic [BYTE_W-1:0] err_code,
  output logic              pend,
  output logic              mask,
  output logic              srst
);
  assign cmd_go = cmd_wr_req && sel && !bsy && !srst;

  always_ff @(posedge clk) begin
    if (rst) begin
      bsy      <= 1'b0;
      rdy      <= 1'b1;
      drq      <= 1'b0;
      err      <= 1'b0;
      err_code <= '0;
      pend     <= 1'b0;
      mask     <= 1'b0;
      srst     <= 1'b0;
    end else begin
      if (srst) begin
        bsy      <= 1'b1;
        rdy      <= 1'b0;
        drq      <= 1'b0;
        err      <= 1'b0;
        err_code <= '0;
        pend     <= 1'b0;
      end else begin
        if (stat_rd)
          pend <= 1'b0;
        if (cmd_go) begin
          bsy  <= 1'b1;
          drq  <= 1'b0;
          err  <= 1'b0;
          pend <= 1'b0;
        end else if (bsy && be_done) begin
          bsy      <= 1'b0;
          drq      <= be_drq;
          err      <= |be_err;
          err_code <= be_err;
          pend     <= 1'b1;
        end
      end
      if (ctl_wr) begin
        mask <= dc_mask;
        srst <= dc_rst;
        if (dc_rst) begin
          bsy <= 1'b1;
          rdy <= 1'b0;
        end else if (srst) begin
          bsy <= 1'b0;
          rdy <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tf_regset.sv
`timescale 1ns/1ps
module tf_regset
  import tf_pkg::*;
#(
  parameter int CNT_DEF = 1,
  parameter int SEC_DEF = 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            is_slave,
  input  logic                            cs0_n,
  input  logic                            cs1_n,
  input  logic [2:0]                      addr,
  input  logic                            rd_n,
  input  logic                            wr_n,
  input  logic [7:0]                      wdata,
  output logic [7:0]                      rdata,
  output logic                            rdata_oe,
  output logic                            irq_o,
  input  logic                            be_done,
  input  logic                            be_drq,
  input  logic [7:0]                      be_err,
  input  logic                            be_index,
  input  logic                            be_corr,
  input  logic                            be_seek_ok,
  input  logic                            be_wfault,
  input  logic                            be_writing,
  output logic                            cmd_start,
  output logic [NUM_PARAM_BYTES*BYTE_W-1:0] tf_params
);
  bus_op_t op;

  tf_decode u_dec (
    .clk(clk), .rst(rst), .cs0_n(cs0_n), .cs1_n(cs1_n), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .op(op)
  );

  logic [BYTE_W-1:0] feat, count, sector, cyl_lo, cyl_hi, cmd, err_code;
  logic [HEAD_W-1:0] head;
  logic dev, sel, cmd_go, soft_rst;
  logic bsy, rdy, drq, err, irq_pend, mask;
  logic stat_rd, alt_rd, ctl_wr, cmd_wr_req;

  assign sel        = (dev == is_slave);
  assign stat_rd    = op.cmd_rd && op.ofs == OFS_STATCMD && sel;
  assign alt_rd     = op.ctl_rd && op.ofs == OFS_ALTCTL && sel;
  assign ctl_wr     = op.ctl_wr && op.ofs == OFS_ALTCTL;
  assign cmd_wr_req = op.cmd_wr && op.ofs == OFS_STATCMD;

  tf_store #(.CNT_DEF(CNT_DEF), .SEC_DEF(SEC_DEF)) u_store (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .wr_en(op.cmd_wr), .wr_ofs(op.ofs), .wdata(wdata), .cmd_go(cmd_go),
    .feat(feat), .count(count), .sector(sector), .cyl_lo(cyl_lo),
    .cyl_hi(cyl_hi), .head(head), .dev(dev), .cmd(cmd)
  );

  tf_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sel(sel), .cmd_wr_req(cmd_wr_req),
    .stat_rd(stat_rd), .ctl_wr(ctl_wr),
    .dc_mask(wdata[DC_MASK_BIT]), .dc_rst(wdata[DC_RST_BIT]),
    .be_done(be_done), .be_drq(be_drq), .be_err(be_err),
    .cmd_go(cmd_go), .bsy(bsy), .rdy(rdy), .drq(drq), .err(err),
    .err_code(err_code), .pend(irq_pend), .mask(mask), .srst(soft_rst)
  );

  logic [BYTE_W-1:0] status_b, headdev_b, drvadr_b;
  assign status_b  = {bsy, rdy, be_wfault, be_seek_ok, drq, be_corr, be_index, err};
  assign headdev_b = {HD_FIXED, dev, head};
  assign drvadr_b  = {1'b0, be_writing, ~head, dev, ~dev};

  assign tf_params = {feat, count, sector, cyl_lo, cyl_hi, headdev_b, cmd};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      rdata_oe  <= 1'b0;
      irq_o     <= 1'b0;
      cmd_start <= 1'b0;
    end else begin
      irq_o     <= irq_pend && !mask && sel;
      cmd_start <= cmd_go;
      rdata     <= '0;
      rdata_oe  <= 1'b0;
      if (op.cmd_rd && sel) begin
        rdata_oe <= (op.ofs != '0);
        case (op.ofs)
          OFS_ERRFEAT: rdata <= err_code;
          OFS_COUNT:   rdata <= count;
          OFS_SECTOR:  rdata <= sector;
          OFS_CYL_LO:  rdata <= cyl_lo;
          OFS_CYL_HI:  rdata <= cyl_hi;
          OFS_HEADDEV: rdata <= headdev_b;
          OFS_STATCMD: rdata <= status_b;
          default:     rdata <= '0;
        endcase
      end else if (op.ctl_rd && sel) begin
        case (op.ofs)
          OFS_ALTCTL: begin rdata <= status_b; rdata_oe <= 1'b1; end
          OFS_DRVADR: begin rdata <= drvadr_b; rdata_oe <= 1'b1; end
          default:    rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tf_regset_chk.sv
`timescale 1ns/1ps
module tf_regset_chk (
  input logic clk,
  input logic rst,
  input logic stat_rd,
  input logic alt_rd,
  input logic ctl_wr,
  input logic cmd_go,
  input logic bsy,
  input logic rdy,
  input logic irq_pend,
  input logic mask,
  input logic soft_rst,
  input logic sel,
  input logic be_done,
  input logic irq_o,
  input logic rdata_oe,
  input logic cmd_start
);
  // R8: interrupt disable keeps the pin low
  a_r8_mask_holds_pin_low: assert property (@(posedge clk) disable iff (rst)
    mask |=> !irq_o);

  // R7: primary status read clears the pending interrupt
  a_r7_status_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !(bsy && be_done)) |=> !irq_pend);

  // R7: alternate status read leaves it pending
  a_r7_alt_read_keeps: assert property (@(posedge clk) disable iff (rst)
    (alt_rd && irq_pend && !soft_rst && !stat_rd && !cmd_go && !ctl_wr) |=> irq_pend);

  // R9: soft reset holds busy and not ready
  a_r9_soft_reset_busy: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !ctl_wr) |=> (bsy && !rdy));

  // R4: accepted command sets busy, start is a single pulse
  a_r4_go_sets_busy: assert property (@(posedge clk) disable iff (rst)
    cmd_go |=> bsy);
  a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !cmd_start);

  // R10: read data only driven by a selected device
  a_r10_oe_needs_sel: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> $past(sel));
endmodule

bind tf_regset tf_regset_chk u_chk (
  .clk(clk), .rst(rst), .stat_rd(stat_rd), .alt_rd(alt_rd), .ctl_wr(ctl_wr),
  .cmd_go(cmd_go), .bsy(bsy), .rdy(rdy), .irq_pend(irq_pend), .mask(mask),
  .soft_rst(soft_rst), .sel(sel), .be_done(be_done), .irq_o(irq_o),
  .rdata_oe(rdata_oe), .cmd_start(cmd_start)
);

// File: tb/tf_regset_test.sv
`timescale 1ns/1ps
module tf_regset_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, is_slave, cs0_n, cs1_n, rd_n, wr_n;
  logic [2:0] addr;
  logic [7:0] wdata, rdata, be_err;
  logic rdata_oe, irq_o, be_done, be_drq, be_index, be_corr, be_seek_ok;
  logic be_wfault, be_writing, cmd_start;
  logic [55:0] tf_params;

  tf_regset uut (
    .clk(clk), .rst(rst), .is_slave(is_slave), .cs0_n(cs0_n), .cs1_n(cs1_n),
    .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .irq_o(irq_o), .be_done(be_done), .be_drq(be_drq),
    .be_err(be_err), .be_index(be_index), .be_corr(be_corr),
    .be_seek_ok(be_seek_ok), .be_wfault(be_wfault), .be_writing(be_writing),
    .cmd_start(cmd_start), .tf_params(tf_params)
  );

  typedef struct {
    logic [7:0] d;
    logic       oe;
    string      tag;
  } exp_t;

  exp_t   expq[$];
  int     total = 0;
  int     bad = 0;
  bit     finished = 0;
  event   smp;

  task automatic note(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  // monitor: compares each read result against the scoreboard queue
  initial begin
    forever begin
      exp_t e;
      @(smp);
      if (expq.size() == 0) begin
        note(1'b0, "scoreboard empty", {23'd0, rdata_oe, rdata}, 0);
      end else begin
        e = expq.pop_front();
        note(rdata == e.d && rdata_oe == e.oe, e.tag,
             {23'd0, rdata_oe, rdata}, {23'd0, e.oe, e.d});
      end
    end
  end

  task automatic bus_wr(input logic c0, input logic c1, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs0_n = c0; cs1_n = c1; addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; cs0_n = 1'b1; cs1_n = 1'b1;
  endtask

  task automatic bus_rd(input logic c0, input logic c1, input logic [2:0] a,
                        input logic [7:0] d, input logic oe, input string tag);
    exp_t e;
    e.d = d; e.oe = oe; e.tag = tag;
    expq.push_back(e);
    @(negedge clk);
    cs0_n = c0; cs1_n = c1; addr = a; rd_n = 1'b0;
    @(negedge clk);
    -> smp;
    rd_n = 1'b1; cs0_n = 1'b1; cs1_n = 1'b1;
  endtask

  task automatic wr_cmd(input logic [2:0] a, input logic [7:0] d);
    bus_wr(1'b0, 1'b1, a, d);
  endtask
  task automatic wr_ctl(input logic [7:0] d);
    bus_wr(1'b1, 1'b0, 3'd6, d);
  endtask
  task automatic rd_cmd(input logic [2:0] a, input logic [7:0] d, input logic oe, input string tag);
    bus_rd(1'b0, 1'b1, a, d, oe, tag);
  endtask
  task automatic rd_ctl(input logic [2:0] a, input logic [7:0] d, input logic oe, input string tag);
    bus_rd(1'b1, 1'b0, a, d, oe, tag);
  endtask

  task automatic finish_cmd(input logic drq, input logic [7:0] code);
    @(negedge clk);
    be_done = 1'b1; be_drq = drq; be_err = code;
    @(negedge clk);
    be_done = 1'b0; be_drq = 1'b0; be_err = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      idle(2);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(100000);
    note(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    rst = 1'b1; is_slave = 1'b0; cs0_n = 1'b1; cs1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = '0; wdata = '0; be_done = 1'b0; be_drq = 1'b0; be_err = '0;
    be_index = 1'b0; be_corr = 1'b0; be_seek_ok = 1'b0; be_wfault = 1'b0; be_writing = 1'b0;
    idle(4);
    rst = 1'b0;
    idle(1);

    // R13 reset state
    note(irq_o == 1'b0, "R13 irq after reset", irq_o, 0);
    note(cmd_start == 1'b0, "R13 cmd_start after reset", cmd_start, 0);
    rd_cmd(3'd7, 8'h40, 1'b1, "R13 status after reset");
    rd_cmd(3'd2, 8'h01, 1'b1, "R13 count default");
    rd_cmd(3'd3, 8'h01, 1'b1, "R13 sector default");
    rd_cmd(3'd6, 8'hA0, 1'b1, "R13 head/device default");

    // R1 parameter registers, R2 head/device format
    wr_cmd(3'd2, 8'h5A);
    wr_cmd(3'd3, 8'h11);
    wr_cmd(3'd4, 8'hC3);
    wr_cmd(3'd5, 8'h02);
    wr_cmd(3'd6, 8'h0A);
    rd_cmd(3'd2, 8'h5A, 1'b1, "R1 count readback");
    rd_cmd(3'd3, 8'h11, 1'b1, "R1 sector readback");
    rd_cmd(3'd4, 8'hC3, 1'b1, "R1 cyl low readback");
    rd_cmd(3'd5, 8'h02, 1'b1, "R1 cyl high readback");
    rd_cmd(3'd6, 8'hAA, 1'b1, "R2 head/device readback");
    rd_cmd(3'd0, 8'h00, 1'b0, "R1 offset 0 no response");
    bus_rd(1'b0, 1'b0, 3'd7, 8'h00, 1'b0, "R1 both selects low");

    // R3 features vs error
    wr_cmd(3'd1, 8'h77);
    rd_cmd(3'd1, 8'h00, 1'b1, "R3 offset 1 reads error");
    note(tf_params[55:48] == 8'h77, "R3 features on tf_params", tf_params[55:48], 8'h77);

    // R11 drive address: head A, master, writing
    be_writing = 1'b1;
    rd_ctl(3'd7, 8'h55, 1'b1, "R11 drive address");
    be_writing = 1'b0;

    // R10 deselected device
    wr_cmd(3'd6, 8'hFF);
    rd_cmd(3'd6, 8'h00, 1'b0, "R10 deselected head/device read");
    rd_ctl(3'd6, 8'h00, 1'b0, "R10 deselected alt status read");
    wr_cmd(3'd7, 8'hEC);
    note(cmd_start == 1'b0, "R10 command ignored when deselected", cmd_start, 0);
    wr_cmd(3'd2, 8'h66);
    wr_cmd(3'd6, 8'h03);
    rd_cmd(3'd6, 8'hA3, 1'b1, "R2 head/device reselect");
    rd_cmd(3'd2, 8'h66, 1'b1, "R10 write accepted while deselected");

    // R4 command start
    wr_cmd(3'd7, 8'hEC);
    note(cmd_start == 1'b1, "R4 cmd_start pulse", cmd_start, 1);
    note(tf_params[7:0] == 8'hEC, "R4 command code", tf_params[7:0], 8'hEC);
    rd_cmd(3'd7, 8'hC0, 1'b1, "R4 busy status");
    wr_cmd(3'd7, 8'h20);
    note(cmd_start == 1'b0, "R4 command ignored while busy", cmd_start, 0);
    note(tf_params[7:0] == 8'hEC, "R4 code kept while busy", tf_params[7:0], 8'hEC);

    // R5, R6, R7 completion with data request
    finish_cmd(1'b1, 8'h00);
    idle(1);
    note(irq_o == 1'b1, "R6 irq after completion", irq_o, 1);
    rd_ctl(3'd6, 8'h48, 1'b1, "R7 alt status byte");
    idle(1);
    note(irq_o == 1'b1, "R7 alt read keeps irq", irq_o, 1);
    rd_cmd(3'd7, 8'h48, 1'b1, "R5 status after completion");
    idle(1);
    note(irq_o == 1'b0, "R7 status read clears irq", irq_o, 0);

    // R5 completion with error
    wr_cmd(3'd7, 8'h91);
    finish_cmd(1'b0, 8'h04);
    rd_cmd(3'd7, 8'h41, 1'b1, "R5 error status");
    rd_cmd(3'd1, 8'h04, 1'b1, "R5 error code");
    wr_cmd(3'd7, 8'h10);
    rd_cmd(3'd7, 8'hC0, 1'b1, "R4 new command clears ERR");
    finish_cmd(1'b0, 8'h00);
    rd_cmd(3'd7, 8'h40, 1'b1, "R5 clean completion");

    // R8 masking
    wr_ctl(8'h02);
    wr_cmd(3'd7, 8'h70);
    finish_cmd(1'b0, 8'h00);
    idle(2);
    note(irq_o == 1'b0, "R8 masked irq", irq_o, 0);
    rd_ctl(3'd6, 8'h40, 1'b1, "R8 alt status while masked");
    wr_ctl(8'h00);
    idle(1);
    note(irq_o == 1'b1, "R8 pending shows after unmask", irq_o, 1);
    rd_cmd(3'd7, 8'h40, 1'b1, "R7 status read after unmask");
    idle(1);
    note(irq_o == 1'b0, "R7 cleared after unmask", irq_o, 0);

    // R12 live status bits
    @(negedge clk);
    be_index = 1'b1; be_corr = 1'b1; be_seek_ok = 1'b1; be_wfault = 1'b1;
    rd_cmd(3'd7, 8'h76, 1'b1, "R12 mirrored status bits");
    be_index = 1'b0; be_corr = 1'b0; be_seek_ok = 1'b0; be_wfault = 1'b0;

    // R9 soft reset
    wr_cmd(3'd7, 8'hEC);
    finish_cmd(1'b0, 8'h00);
    idle(1);
    note(irq_o == 1'b1, "R9 irq pending before soft reset", irq_o, 1);
    wr_ctl(8'h04);
    rd_ctl(3'd6, 8'h80, 1'b1, "R9 status in soft reset");
    idle(1);
    note(irq_o == 1'b0, "R9 soft reset drops irq", irq_o, 0);
    rd_cmd(3'd2, 8'h01, 1'b1, "R9 count default");
    rd_cmd(3'd4, 8'h00, 1'b1, "R9 cyl low default");
    rd_cmd(3'd6, 8'hA0, 1'b1, "R9 head/device default");
    wr_ctl(8'h00);
    rd_cmd(3'd7, 8'h40, 1'b1, "R9 ready after soft reset");

    // R14 held strobe loads first data only
    @(negedge clk);
    cs0_n = 1'b0; cs1_n = 1'b1; addr = 3'd2; wdata = 8'h11; wr_n = 1'b0;
    @(negedge clk);
    wdata = 8'h22;
    @(negedge clk);
    wdata = 8'h33;
    @(negedge clk);
    wr_n = 1'b1; cs0_n = 1'b1; cs1_n = 1'b1;
    rd_cmd(3'd2, 8'h11, 1'b1, "R14 held write strobe");

    // R10 slave strap
    @(negedge clk);
    is_slave = 1'b1;
    rd_cmd(3'd7, 8'h00, 1'b0, "R10 slave strap, device 0 selected");
    wr_cmd(3'd7, 8'hEC);
    note(cmd_start == 1'b0, "R10 slave ignores command for device 0", cmd_start, 0);
    wr_cmd(3'd6, 8'h10);
    rd_cmd(3'd7, 8'h40, 1'b1, "R10 slave responds when selected");
    rd_ctl(3'd7, 8'h3E, 1'b1, "R11 drive address as slave");

    idle(2);
    note(expq.size() == 0, "scoreboard drained", expq.size(), 0);
    summary();
  end
endmodule